// File: doc/BRIEF.md
# Receive Ring Configuration and Pointer Registers

This block keeps the register state that describes a receive ring buffer placed in host memory. It holds a 32-bit receive configuration word, the ring base address, the ring write pointer and the host read pointer. From a two-bit field of the configuration word it derives the ring size, which is 8 KiB, 16 KiB, 32 KiB or 64 KiB. A receive DMA engine outside this block uses the ring size and the pointers, and it loads the write pointer as it fills the ring.

The host reaches the registers over a plain single-cycle bus. The bus has a write strobe, a two-bit register select and 32-bit write data, and it returns read data one clock later. Some configuration bits are protected and keep their value through a write. Any configuration write also resets both pointers to the start of the ring. The host read pointer is stored with a bias of +16 and wraps at the ring size. When the host reads it back, the block removes the bias.

Top module: `rx_ring_ptr_regs`

## Requirements
- R1: After reset the configuration word, ring base, write pointer and stored read pointer are all zero. The ring size is 8192, and a read of the read-pointer register (select 1) returns 0x0000FFF0.
- R2: A write to select 0 updates the configuration word. Bits set in the protection mask 0xF0FC0040 keep their old value, and all other bits take the written value.
- R3: The ring size equals 8192 shifted left by configuration bits [12:11].
- R4: A configuration write sets both the write pointer and the stored read pointer to zero in the next cycle. This also happens when the DMA loads the write pointer in the same cycle.
- R5: A write of V to select 1 stores (V + 16) modulo the current ring size as the read pointer.
- R6: A read of select 1 returns the stored read pointer minus 16, truncated to 16 bits and zero-extended to 32 bits.
- R7: Select 2 is a plain 32-bit read/write ring base register. Writing it leaves both pointers unchanged.
- R8: A DMA load stores its value modulo the current ring size as the write pointer.
- R9: Read data is registered. In the cycle after a given select, host_rdata shows the register chosen by that select (0 configuration, 1 read pointer, 2 base). Select 3 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host write strobe |
| host_sel | input | 2 | Register select |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Registered host read data |
| dma_wp_load | input | 1 | DMA write-pointer load strobe |
| dma_wp_value | input | 16 | New write pointer from the DMA |
| ring_size | output | 17 | Ring size in bytes |
| ring_wr_ptr | output | 16 | Ring write pointer |
| ring_rd_ptr | output | 16 | Stored (biased) host read pointer |
| ring_base | output | 32 | Ring base address |

## Verification
The bench builds the block with its default parameters: a minimum ring of 8 KiB, a size field at bits [12:11], a bias of 16 and the standard protection mask. With these values all four ring sizes can be reached, including the 64 KiB case, where the biased pointer fills all 16 bits. The bias wrap can be seen directly: a write near 0xFFFF folds back to a small stored value, and it still reads back as the value written. Writing ones to every configuration bit shows that the protected bits cannot be set.

// File: rtl/rx_ring_ptr_regs.sv
module rx_ring_ptr_regs #(
  parameter logic [31:0] CFG_KEEP_MASK = 32'hF0FC0040,
  parameter int MIN_LOG2 = 13,
  parameter int SIZE_LSB = 11,
  parameter int PTR_BIAS = 16,
  localparam int PTR_W  = MIN_LOG2 + 3,
  localparam int SIZE_W = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [1:0]        host_sel,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  input  logic              dma_wp_load,
  input  logic [PTR_W-1:0]  dma_wp_value,
  output logic [SIZE_W-1:0] ring_size,
  output logic [PTR_W-1:0]  ring_wr_ptr,
  output logic [PTR_W-1:0]  ring_rd_ptr,
  output logic [31:0]       ring_base
);
  localparam logic [1:0] SEL_CFG  = 2'd0;
  localparam logic [1:0] SEL_RDP  = 2'd1;
  localparam logic [1:0] SEL_BASE = 2'd2;

  logic [31:0]      cfg_q;
  logic [PTR_W-1:0] wrap_mask;
  logic             cfg_wr, rdp_wr, base_wr;
  logic [31:0]      rdp_biased;
  logic [PTR_W-1:0] rdp_unbiased;

  assign cfg_wr  = host_we && host_sel == SEL_CFG;
  assign rdp_wr  = host_we && host_sel == SEL_RDP;
  assign base_wr = host_we && host_sel == SEL_BASE;

  assign ring_size    = SIZE_W'(1) << (MIN_LOG2 + int'(cfg_q[SIZE_LSB+1:SIZE_LSB]));
  assign wrap_mask    = PTR_W'(ring_size - SIZE_W'(1));
  assign rdp_biased   = host_wdata + 32'(PTR_BIAS);
  assign rdp_unbiased = ring_rd_ptr - PTR_W'(PTR_BIAS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q       <= '0;
      ring_base   <= '0;
      ring_wr_ptr <= '0;
      ring_rd_ptr <= '0;
      host_rdata  <= '0;
    end else begin
      unique case (host_sel)
        SEL_CFG:  host_rdata <= cfg_q;
        SEL_RDP:  host_rdata <= 32'(rdp_unbiased);
        SEL_BASE: host_rdata <= ring_base;
        default:  host_rdata <= '0;
      endcase
      if (base_wr) ring_base <= host_wdata;
      if (cfg_wr) begin
        cfg_q       <= (cfg_q & CFG_KEEP_MASK) | (host_wdata & ~CFG_KEEP_MASK);
        ring_wr_ptr <= '0;
        ring_rd_ptr <= '0;
      end else begin
        if (dma_wp_load) ring_wr_ptr <= dma_wp_value & wrap_mask;
        if (rdp_wr)      ring_rd_ptr <= PTR_W'(rdp_biased) & wrap_mask;
      end
    end
  end
endmodule

// File: rtl/rx_ring_ptr_regs_chk.sv
module rx_ring_ptr_regs_chk #(
  parameter logic [31:0] KEEP = 32'hF0FC0040,
  parameter int PW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          host_we,
  input logic [1:0]    host_sel,
  input logic [31:0]   host_rdata,
  input logic          dma_wp_load,
  input logic [31:0]   cfg_q,
  input logic [PW:0]   ring_size,
  input logic [PW-1:0] ring_wr_ptr,
  input logic [PW-1:0] ring_rd_ptr
);
  // R4
  cfg_resets_ptrs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_we && host_sel == 2'd0 |=> ring_wr_ptr == '0 && ring_rd_ptr == '0);
  // R2
  cfg_keep_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_we && host_sel == 2'd0 |=> (cfg_q & KEEP) == $past(cfg_q & KEEP));
  // R5
  rd_ptr_in_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, ring_rd_ptr} < ring_size);
  // R8
  wr_ptr_in_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, ring_wr_ptr} < ring_size);
  // R7
  base_no_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_we && host_sel == 2'd2 && !dma_wp_load |=> $stable(ring_wr_ptr) && $stable(ring_rd_ptr));
  // R9
  sel3_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_sel == 2'd3 |=> host_rdata == '0);
  // R3
  size_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(ring_size) == 1 && ring_size >= (PW+1)'(8192));
endmodule

bind rx_ring_ptr_regs rx_ring_ptr_regs_chk #(.KEEP(CFG_KEEP_MASK), .PW(PTR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_sel(host_sel),
  .host_rdata(host_rdata), .dma_wp_load(dma_wp_load), .cfg_q(cfg_q),
  .ring_size(ring_size), .ring_wr_ptr(ring_wr_ptr), .ring_rd_ptr(ring_rd_ptr)
);

// File: tb/rx_ring_ptr_regs_bench.sv
module rx_ring_ptr_regs_bench;
  logic        clk = 0, rst_n = 0;
  logic        host_we = 0;
  logic [1:0]  host_sel = 0;
  logic [31:0] host_wdata = 0;
  logic [31:0] host_rdata;
  logic        dma_wp_load = 0;
  logic [15:0] dma_wp_value = 0;
  logic [16:0] ring_size;
  logic [15:0] ring_wr_ptr, ring_rd_ptr;
  logic [31:0] ring_base;

  int tests = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rx_ring_ptr_regs u_rx_ring_ptr_regs (.*);

  // behavioural reference
  longint m_cfg, m_base, m_wp, m_rp, m_rdata;
  function automatic longint msize();
    return 64'd8192 << ((m_cfg >> 11) & 3);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cfg = 0; m_base = 0; m_wp = 0; m_rp = 0; m_rdata = 0;
    end else begin
      case (host_sel)
        2'd0: m_rdata = m_cfg;
        2'd1: m_rdata = (m_rp + 65536 - 16) % 65536;
        2'd2: m_rdata = m_base;
        default: m_rdata = 0;
      endcase
      if (host_we && host_sel == 2'd2) m_base = host_wdata;
      if (host_we && host_sel == 2'd0) begin
        m_cfg = (m_cfg & 64'hF0FC0040) | (host_wdata & 64'h0F03FFBF);
        m_wp = 0; m_rp = 0;
      end else begin
        if (dma_wp_load) m_wp = dma_wp_value % msize();
        if (host_we && host_sel == 2'd1) m_rp = (longint'(host_wdata) + 16) % msize();
      end
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // compare against the model every clock, away from the edge
  always @(negedge clk) if (rst_n && !done) begin
    check(host_rdata == 32'(m_rdata), "R9 rdata", host_rdata, m_rdata);
    check(ring_size == 17'(msize()), "R3 size", ring_size, msize());
    check(ring_wr_ptr == 16'(m_wp), "R8 wr_ptr", ring_wr_ptr, m_wp);
    check(ring_rd_ptr == 16'(m_rp), "R5 rd_ptr", ring_rd_ptr, m_rp);
    check(ring_base == 32'(m_base), "R7 base", ring_base, m_base);
  end

  task automatic wr(input logic [1:0] s, input logic [31:0] v);
    @(negedge clk); host_we = 1; host_sel = s; host_wdata = v;
    @(negedge clk); host_we = 0;
  endtask

  task automatic rd(input logic [1:0] s, input logic [31:0] exp, input string req);
    @(negedge clk); host_sel = s;
    @(negedge clk);
    check(host_rdata == exp, req, host_rdata, exp);
  endtask

  task automatic dma(input logic [15:0] v);
    @(negedge clk); dma_wp_load = 1; dma_wp_value = v;
    @(negedge clk); dma_wp_load = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    @(negedge clk);
    check(ring_size == 17'd8192 && ring_wr_ptr == 0 && ring_rd_ptr == 0 && ring_base == 0,
          "R1 reset", {ring_size, ring_wr_ptr}, 17'd8192 << 16);
    rd(2'd0, 32'h0, "R1 cfg");
    rd(2'd1, 32'h0000FFF0, "R1_R6 rdp");
    // R2 protected bits
    wr(2'd0, 32'hFFFFFFFF);
    rd(2'd0, 32'h0F03FFBF, "R2 mask");
    check(ring_size == 17'h10000, "R3 64K", ring_size, 17'h10000);
    // R5 / R6 at 64K: bias fills 16 bits
    wr(2'd1, 32'h0000FFF0);
    check(ring_rd_ptr == 16'h0, "R5 wrap64K", ring_rd_ptr, 0);
    rd(2'd1, 32'h0000FFF0, "R6 read64K");
    dma(16'h1234);
    wr(2'd1, 32'h100);
    // R4 reset on config write, size 16K
    wr(2'd0, 32'h00000800);
    check(ring_wr_ptr == 0 && ring_rd_ptr == 0, "R4 reset ptrs", {ring_wr_ptr, ring_rd_ptr}, 0);
    check(ring_size == 17'd16384, "R3 16K", ring_size, 17'd16384);
    rd(2'd0, 32'h00000800, "R2 cleared");
    // R8 masked DMA load
    dma(16'hFFFF);
    check(ring_wr_ptr == 16'h3FFF, "R8 mask", ring_wr_ptr, 16'h3FFF);
    // R4 config write wins over simultaneous DMA load
    @(negedge clk); host_we = 1; host_sel = 0; host_wdata = 32'h0; dma_wp_load = 1; dma_wp_value = 16'h55;
    @(negedge clk); host_we = 0; dma_wp_load = 0;
    check(ring_wr_ptr == 0, "R4 vs dma", ring_wr_ptr, 0);
    // R5/R6 at 8K wrap
    wr(2'd1, 32'h0000FFF8);
    check(ring_rd_ptr == 16'h0008, "R5 wrap8K", ring_rd_ptr, 8);
    rd(2'd1, 32'h0000FFF8, "R6 read8K");
    // R7 base no side effect
    dma(16'h0123);
    wr(2'd2, 32'hDEADBEEF);
    check(ring_wr_ptr == 16'h0123 && ring_rd_ptr == 16'h0008, "R7 ptrs kept",
          {ring_wr_ptr, ring_rd_ptr}, {16'h0123, 16'h0008});
    rd(2'd2, 32'hDEADBEEF, "R7 base");
    rd(2'd3, 32'h0, "R9 sel3");
    // mixed traffic against the model
    begin
      logic [31:0] lcg = 32'h1357_9BDF;
      for (int i = 0; i < 400; i++) begin
        lcg = lcg * 32'd1664525 + 32'd1013904223;
        @(negedge clk);
        host_we = lcg[3] & lcg[9]; host_sel = lcg[5:4]; host_wdata = {lcg[31:16], lcg[7:0], lcg[23:16]};
        dma_wp_load = lcg[12]; dma_wp_value = lcg[31:16];
      end
      @(negedge clk); host_we = 0; dma_wp_load = 0;
    end
    repeat (2) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule